// File: doc/BRIEF.md
# Fractional Pacing Request Timer Bank

This block turns the system clock into a stream of single-cycle request strobes whose average rate is an exact rational fraction of the clock. Each timer in the bank holds a numerator and a denominator. Every cycle it adds the numerator to a running remainder. When the remainder reaches the denominator, the timer takes the denominator off the remainder and raises its strobe for one cycle. A DMA channel, or any other consumer that needs steady pacing, uses the strobe as its request line.

The bank holds `NUM_TIMERS` independent timers, two by default. Each is configured with one write of a packed word to the timer picked by the select input. The numerator sits in the upper half of the word and the denominator in the lower half. A write clears that timer's remainder, so the pattern that follows always starts from the same phase. The stored word of the selected timer can be read back on a combinational read bus.

Top module: `pace_timer_bank`

## Requirements
- R1: A write with `cfg_wr`=1 stores `cfg_wdata` in the timer indexed by `cfg_sel`, with the numerator in bits [31:16] and the denominator in bits [15:0]. From the next cycle, `cfg_rdata` returns the stored word of the selected timer. A select value with no timer returns zero.
- R2: For a numerator N and denominator D with 0 < N < D, exactly N*m strobes appear in the first D*m cycles after a write, for any m ≥ 1.
- R3: After a write with 0 < N < D, the first strobe appears in the cycle that follows the ceil(D/N)-th clock edge after the write edge.
- R4: When N equals D and both are non-zero, the strobe is high in every cycle after the write edge.
- R5: When N is greater than D and D is non-zero, the strobe saturates and is high in every cycle after the write edge.
- R6: When N or D is zero, the strobe never goes high.
- R7: A write clears the timer's remainder and holds its strobe low in the cycle after the write edge, so rewriting a running timer restarts its phase.
- R8: A write to one timer does not change the stored word, the phase or the strobe pattern of any other timer.
- R9: After reset, all stored words are zero and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_sel | input | SEL_W (1) | Index of the timer that is written and read |
| cfg_wdata | input | DATA_W (32) | Packed word: numerator [31:16], denominator [15:0] |
| cfg_rdata | output | DATA_W (32) | Stored word of the selected timer |
| req_o | output | NUM_TIMERS (2) | One request strobe per timer |

## Verification
The hardest case to reach is the restart of a timer that is part way through its pattern. The remainder is not visible at the ports, so a wrong clear only shows up as a strobe that arrives a few cycles early. The bench sets a slow fraction, lets the remainder build for a few cycles, and rewrites the same word. It then checks that the first strobe keeps its full ceil(D/N) distance from the rewrite and does not come early. For independence, the bench writes the second timer in the middle of the first timer's counting window. It then requires the first timer's strobe count for that window to stay exact.

// File: rtl/pace_pkg.sv
package pace_pkg;

   // Width of a timer index; never below one bit.
   function automatic int sel_width(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pace_cfg_reg.sv
module pace_cfg_reg #(
   parameter int NUM_W = 16,
   parameter int DEN_W = 16,
   localparam int WORD_W = NUM_W + DEN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] word_o,
   output logic [NUM_W-1:0]  num_o,
   output logic [DEN_W-1:0]  den_o
);

   logic [WORD_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     word_q <= '0;
      else if (wr_en) word_q <= wdata;
   end

   assign word_o = word_q;
   assign num_o  = word_q[WORD_W-1 -: NUM_W];
   assign den_o  = word_q[DEN_W-1:0];

   AST_WORD_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> word_q == $past(wdata)); // R1

   AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(word_q)); // R8

endmodule

// File: rtl/pace_accum.sv
module pace_accum #(
   parameter int NUM_W   = 16,
   parameter int DEN_W   = 16,
   parameter bit REQ_REG = 1'b1,
   localparam int SUM_W  = pace_pkg::max_int(NUM_W, DEN_W) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             req_o
);

   logic [DEN_W-1:0] acc_q;
   logic [DEN_W-1:0] acc_nxt;
   logic [SUM_W-1:0] num_x;
   logic [SUM_W-1:0] den_x;
   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] diff;
   logic             idle;
   logic             sat;
   logic             hit;

   assign num_x = SUM_W'(num);
   assign den_x = SUM_W'(den);
   assign sum   = SUM_W'(acc_q) + num_x;
   assign diff  = sum - den_x;
   assign idle  = (num == '0) || (den == '0);
   assign sat   = num_x >= den_x;
   assign hit   = !idle && (sat || (sum >= den_x));

   always_comb begin
      if (restart || idle || sat) acc_nxt = '0;
      else if (hit)               acc_nxt = DEN_W'(diff);
      else                        acc_nxt = DEN_W'(sum);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_nxt;
   end

   generate
      if (REQ_REG) begin : g_req_reg
         logic req_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= hit && !restart;
         end
         assign req_o = req_q;

         AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
            (!restart && num != '0 && den != '0 && num_x >= den_x) |=> req_o); // R5

         AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (num == '0 || den == '0) |=> !req_o); // R6

         AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            restart |=> (acc_q == '0) && !req_o); // R7
      end else begin : g_req_comb
         assign req_o = hit && !restart;

         AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            restart |=> (acc_q == '0)); // R7
      end
   endgenerate

   AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (den == '0) || (acc_q < den)); // R2

endmodule

// File: rtl/pace_timer_bank.sv
module pace_timer_bank #(
   parameter int NUM_TIMERS = 2,
   parameter int NUM_W      = 16,
   parameter int DEN_W      = 16,
   parameter bit REQ_REG    = 1'b1,
   localparam int DATA_W    = NUM_W + DEN_W,
   localparam int SEL_W     = pace_pkg::sel_width(NUM_TIMERS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_wr,
   input  logic [SEL_W-1:0]      cfg_sel,
   input  logic [DATA_W-1:0]     cfg_wdata,
   output logic [DATA_W-1:0]     cfg_rdata,
   output logic [NUM_TIMERS-1:0] req_o
);

   generate
      if (NUM_TIMERS < 1 || NUM_TIMERS > 64) begin : g_bad_count
         $error("pace_timer_bank: NUM_TIMERS must lie in 1..64");
      end
      if (NUM_W < 1 || DEN_W < 2) begin : g_bad_width
         $error("pace_timer_bank: fraction fields too narrow");
      end
   endgenerate

   logic [DATA_W-1:0] words [NUM_TIMERS];

   generate
      for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
         logic             wr_i;
         logic [NUM_W-1:0] num_i;
         logic [DEN_W-1:0] den_i;

         assign wr_i = cfg_wr && (cfg_sel == SEL_W'(i));

         pace_cfg_reg #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_cfg (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_i),
            .wdata  (cfg_wdata),
            .word_o (words[i]),
            .num_o  (num_i),
            .den_o  (den_i)
         );

         pace_accum #(.NUM_W(NUM_W), .DEN_W(DEN_W), .REQ_REG(REQ_REG)) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (wr_i),
            .num     (num_i),
            .den     (den_i),
            .req_o   (req_o[i])
         );
      end
   endgenerate

   always_comb begin
      cfg_rdata = '0;
      for (int k = 0; k < NUM_TIMERS; k++) begin
         if (cfg_sel == SEL_W'(k)) cfg_rdata = words[k];
      end
   end

   AST_RESET_QUIET: assert property (@(posedge clk)
      $rose(rst_n) |-> (req_o == '0)); // R9

endmodule

// File: tb/pace_timer_bank_test.sv
`timescale 1ns/1ps
module pace_timer_bank_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [0:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [1:0]  req_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   pace_timer_bank uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .req_o     (req_o)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Write a timer; returns at the falling edge after the write edge.
   task automatic write_cfg(input int sel, input int x, input int y);
      @(negedge clk);
      cfg_wr    = 1'b1;
      cfg_sel   = 1'(sel);
      cfg_wdata = {16'(x), 16'(y)};
      @(negedge clk);
      cfg_wr    = 1'b0;
   endtask

   task automatic count_window(input int sel, input int n, output int cnt);
      cnt = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (req_o[sel]) cnt++;
      end
   endtask

   task automatic t_reset();
      check("R9 strobes after reset", req_o, 0);
      cfg_sel = 1'b0; #0.1;
      check("R9 timer0 word after reset", cfg_rdata, 0);
      cfg_sel = 1'b1; #0.1;
      check("R9 timer1 word after reset", cfg_rdata, 0);
   endtask

   task automatic t_readback();
      write_cfg(0, 16'h1234, 16'h5678);
      cfg_sel = 1'b0; #0.1;
      check("R1 timer0 readback", cfg_rdata, 32'h1234_5678);
      write_cfg(1, 16'h00AB, 16'hFFFE);
      cfg_sel = 1'b1; #0.1;
      check("R1 timer1 readback", cfg_rdata, 32'h00AB_FFFE);
      cfg_sel = 1'b0; #0.1;
      check("R8 timer0 word kept", cfg_rdata, 32'h1234_5678);
   endtask

   task automatic t_rate(input int x, input int y, input int m);
      int cnt;
      write_cfg(0, x, y);
      check("R7 strobe low after write", req_o[0], 0);
      count_window(0, y * m, cnt);
      check($sformatf("R2 rate %0d/%0d", x, y), cnt, x * m);
   endtask

   task automatic t_first(input int x, input int y);
      int first = 0;
      write_cfg(0, x, y);
      for (int i = 1; i <= y + 2; i++) begin
         @(negedge clk);
         if (req_o[0] && first == 0) first = i;
      end
      check($sformatf("R3 first strobe %0d/%0d", x, y), first, (y + x - 1) / x);
   endtask

   task automatic t_full(input int x, input int y, input string req);
      int cnt;
      write_cfg(0, x, y);
      count_window(0, 20, cnt);
      check($sformatf("%s continuous %0d/%0d", req, x, y), cnt, 20);
   endtask

   task automatic t_zero(input int x, input int y);
      int cnt;
      write_cfg(1, x, y);
      count_window(1, 40, cnt);
      check($sformatf("R6 silent %0d/%0d", x, y), cnt, 0);
   endtask

   task automatic t_restart();
      int first = 0;
      write_cfg(0, 1, 4);
      @(negedge clk);
      @(negedge clk);
      write_cfg(0, 1, 4);
      check("R7 strobe low after rewrite", req_o[0], 0);
      for (int i = 1; i <= 6; i++) begin
         @(negedge clk);
         if (req_o[0] && first == 0) first = i;
      end
      check("R7 phase restarted", first, 4);
   endtask

   task automatic t_indep();
      int cnt = 0;
      write_cfg(0, 1, 2);
      for (int i = 0; i < 8; i++) begin
         if (i == 3) begin
            cfg_wr = 1'b1; cfg_sel = 1'b1; cfg_wdata = {16'd3, 16'd3};
         end else begin
            cfg_wr = 1'b0;
         end
         @(negedge clk);
         if (req_o[0]) cnt++;
      end
      cfg_wr = 1'b0;
      check("R8 timer0 count undisturbed", cnt, 4);
      cfg_sel = 1'b1; #0.1;
      check("R1 timer1 word written", cfg_rdata, {16'd3, 16'd3});
      @(negedge clk);
      check("R4 timer1 full rate", req_o[1], 1);
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_readback();
      t_rate(3, 7, 3);
      t_rate(5, 16, 2);
      t_rate(1, 4, 4);
      t_first(3, 10);
      t_first(1, 4);
      t_first(7, 8);
      t_full(9, 9, "R4");
      t_full(16'hFFFF, 16'hFFFF, "R4");
      t_full(200, 3, "R5");
      t_zero(0, 5);
      t_zero(5, 0);
      t_zero(0, 0);
      t_restart();
      t_indep();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule